// File: doc/BRIEF.md
# PLL Lock and Bandwidth Controller

This block is the digital supervisor of a clock-multiplying PLL. Once per measurement window of `WIN` reference cycles it counts the edges of the divided VCO clock. It compares that count with the expected value `N*WIN` and takes the absolute difference as the frequency error. The error drives two hysteretic flags. `acq` selects the loop-filter bandwidth: 0 means wide-band acquisition and 1 means narrow-band tracking. `lock` reports that the loop is locked and that the VCO may serve as the base clock (`vco_safe`). The analog loop and the base clock mux are outside this block.

The VCO-domain edge counter hands each result to the reference domain through a toggle request/acknowledge handshake. A five-state machine runs the measurement: `ST_OFF`, `ST_PRIME`, `ST_DROP`, `ST_COUNT` and `ST_SYNC`. Its transitions are:
- `ST_OFF`→`ST_PRIME` when `pll_on` is high and no handshake is outstanding.
- `ST_PRIME`→`ST_DROP` at the end of a window, when a capture is requested.
- `ST_DROP`→`ST_COUNT` when the acknowledge returns. The first, partial result is dropped.
- `ST_COUNT`→`ST_SYNC` at the end of each window.
- `ST_SYNC`→`ST_COUNT` when the acknowledge returns, delivering one valid measurement.
- Any state→`ST_OFF` when `pll_on` is low.

In automatic bandwidth mode the hardware owns both flags, and a change of `lock` can raise a sticky interrupt. In manual mode software writes `acq`, while `lock` and the interrupt are held off.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset `acq`, `lock`, `irq` and `vco_safe` are all 0.
- R2: In automatic mode (`auto_bw`=1) `acq` becomes 1 after a measurement with error ≤ `TRK_IN` (default 4). It stays 1 while errors are ≤ `TRK_OUT` (default 14) and returns to 0 after a measurement with error > `TRK_OUT`. From 0 it does not rise on errors above `TRK_IN`.
- R3: In automatic mode `lock` becomes 1 after a measurement with error ≤ `LCK_IN` (default 3). It stays 1 while errors are ≤ `LCK_OUT` (default 9) and returns to 0 after a measurement with error > `LCK_OUT`. From 0 it does not rise on errors above `LCK_IN`.
- R4: A measurement is the number of `vco_clk` rising edges between two captures spaced `WIN` (16) reference cycles apart, compared with `N*WIN` (8*16=128). The first result after enable is discarded.
- R5: `irq` is set on every change of `lock`, rising or falling, while `auto_bw`=1 and `irq_en`=1. With `irq_en`=0 a change of `lock` leaves `irq` at 0.
- R6: A one-cycle pulse on `irq_clr` clears a pending `irq`, which stays 0 until the next change of `lock`. A new change in the same cycle takes precedence over the clear.
- R7: In manual mode (`auto_bw`=0) an accepted write (`acq_we`) copies `acq_wdata` to `acq` on the next clock edge. `lock` is 0 from the cycle after `auto_bw` falls, and `irq` is never set.
- R8: In manual mode a write of 1 to `acq` is ignored until `T_ACQ` (64) reference cycles have passed with `pll_on`=1. A write of 0 is always accepted.
- R9: When `pll_on` is 0, `acq` and `lock` are 0 one cycle later, and the measurement restarts from `ST_PRIME` on the next enable.
- R10: `vco_safe` equals `lock` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| vco_clk | input | 1 | Divided VCO clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pll_on | input | 1 | PLL enable |
| auto_bw | input | 1 | 1 = automatic bandwidth control, 0 = manual |
| irq_en | input | 1 | Lock-change interrupt enable |
| acq_we | input | 1 | Write strobe for the manual filter-mode bit |
| acq_wdata | input | 1 | Value written to `acq` in manual mode |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| acq | output | 1 | Filter mode: 0 acquisition, 1 tracking |
| lock | output | 1 | PLL locked indicator |
| irq | output | 1 | Pending lock-change interrupt |
| vco_safe | output | 1 | VCO clock may be selected as base clock |

## Verification
The bench moves the VCO frequency to error points of about 0, 7, 12 and 20 counts, on both sides of the target. This separates the enter and exit thresholds of each flag. A design with one threshold instead of a band would drop `lock` at error 7 or raise it there coming from a far frequency. A design that swapped the lock and tracking bands would lose `acq` at error 12 along with `lock`. The interrupt is checked on a rising lock, on a falling lock, with the enable off and around the clear. A design that only flagged rising lock would miss the second case. In manual mode the bench writes `acq`=1 too early, then after the acquisition time, and then switches away from automatic mode while locked. A missing guard would take the early write, and a missing override would leave `lock` or `irq` set.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PRIME,
        ST_DROP,
        ST_COUNT,
        ST_SYNC
    } meas_state_t;

    function automatic logic [15:0] abs_err16(input logic [15:0] a, input logic [15:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/plc_vco_counter.sv
module plc_vco_counter #(
    parameter int CW = 12
) (
    input  logic          vco_clk,
    input  logic          rst_n,
    input  logic          req_tgl,
    output logic [CW-1:0] hold,
    output logic          ack_tgl
);
    logic [2:0]    req_sync;
    logic [CW-1:0] edge_cnt;
    logic          capture;

    assign capture = req_sync[2] ^ req_sync[1];

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_sync <= '0;
            edge_cnt <= '0;
            hold     <= '0;
            ack_tgl  <= 1'b0;
        end else begin
            req_sync <= {req_sync[1:0], req_tgl};
            if (capture) begin
                hold     <= edge_cnt;
                edge_cnt <= CW'(1);
                ack_tgl  <= ~ack_tgl;
            end else begin
                edge_cnt <= edge_cnt + CW'(1);
            end
        end
    end

    // Held result only changes together with a new acknowledge toggle (R4)
    p_hold_with_ack_r4: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (ack_tgl == $past(ack_tgl)) |-> $stable(hold));

endmodule

// File: rtl/plc_meas_fsm.sv
module plc_meas_fsm
    import pll_lock_pkg::*;
#(
    parameter int WIN = 16,
    parameter int CW  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pll_on,
    input  logic          ack_tgl,
    input  logic [CW-1:0] hold,
    output logic          req_tgl,
    output logic          meas_valid,
    output logic [CW-1:0] meas_val
);
    localparam int WW = $clog2(WIN);

    meas_state_t   state, state_nx;
    logic [WW-1:0] win_cnt;
    logic          win_end;
    logic [1:0]    ack_sync;
    logic          hs_idle;
    logic          req_flip;
    logic          deliver;

    assign win_end = (win_cnt == WW'(WIN - 1));
    assign hs_idle = (ack_sync[1] == req_tgl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        req_flip = 1'b0;
        deliver  = 1'b0;
        if (!pll_on) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   if (hs_idle) state_nx = ST_PRIME;
                ST_PRIME: if (win_end) begin state_nx = ST_DROP; req_flip = 1'b1; end
                ST_DROP:  if (hs_idle) state_nx = ST_COUNT;
                ST_COUNT: if (win_end) begin state_nx = ST_SYNC; req_flip = 1'b1; end
                ST_SYNC:  if (hs_idle) begin state_nx = ST_COUNT; deliver = 1'b1; end
                default:  state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt    <= '0;
            ack_sync   <= '0;
            req_tgl    <= 1'b0;
            meas_valid <= 1'b0;
            meas_val   <= '0;
        end else begin
            ack_sync   <= {ack_sync[0], ack_tgl};
            win_cnt    <= (state == ST_OFF || win_end) ? '0 : win_cnt + WW'(1);
            if (req_flip) req_tgl <= ~req_tgl;
            meas_valid <= deliver;
            if (deliver) meas_val <= hold;
        end
    end

    // A capture must complete before the next window ends (R4)
    p_ack_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC || state == ST_DROP) |-> !win_end);

    // Disabling returns the machine to idle (R9)
    p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |=> (state == ST_OFF) && !meas_valid);

endmodule

// File: rtl/plc_hyst_flag.sv
module plc_hyst_flag #(
    parameter int CW    = 12,
    parameter int ENTER = 3,
    parameter int EXIT  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load_en,
    input  logic          load_val,
    input  logic          eval,
    input  logic [CW-1:0] err,
    output logic          flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  flag <= 1'b0;
        else if (clear)                              flag <= 1'b0;
        else if (load_en)                            flag <= load_val;
        else if (eval && err <= CW'(ENTER))          flag <= 1'b1;
        else if (eval && err > CW'(EXIT))            flag <= 1'b0;
    end

    // Hardware entry only from inside the tight band (R2, R3)
    p_enter_in_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && !$past(load_en)) |-> ($past(eval) && $past(err) <= CW'(ENTER)));

    // Hardware exit only from outside the wide band (R3, R2)
    p_exit_out_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag) && !$past(clear) && !$past(load_en)) |-> ($past(eval) && $past(err) > CW'(EXIT)));

endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
    import pll_lock_pkg::*;
#(
    parameter int N       = 8,
    parameter int WIN     = 16,
    parameter int CW      = 12,
    parameter int LCK_IN  = 3,
    parameter int LCK_OUT = 9,
    parameter int TRK_IN  = 4,
    parameter int TRK_OUT = 14,
    parameter int T_ACQ   = 64
) (
    input  logic ref_clk,
    input  logic vco_clk,
    input  logic rst_n,
    input  logic pll_on,
    input  logic auto_bw,
    input  logic irq_en,
    input  logic acq_we,
    input  logic acq_wdata,
    input  logic irq_clr,
    output logic acq,
    output logic lock,
    output logic irq,
    output logic vco_safe
);
    localparam int EXPECT = N * WIN;
    localparam int TW     = $clog2(T_ACQ + 1);

    logic          req_tgl, ack_tgl;
    logic [CW-1:0] hold, meas_val, err;
    logic          meas_valid;
    logic [TW-1:0] tacq_cnt;
    logic          acq_ready, acq_wr_ok;
    logic          lock_prev;

    plc_vco_counter #(.CW(CW)) u_vcnt (
        .vco_clk(vco_clk), .rst_n(rst_n), .req_tgl(req_tgl),
        .hold(hold), .ack_tgl(ack_tgl));

    plc_meas_fsm #(.WIN(WIN), .CW(CW)) u_fsm (
        .clk(ref_clk), .rst_n(rst_n), .pll_on(pll_on), .ack_tgl(ack_tgl),
        .hold(hold), .req_tgl(req_tgl), .meas_valid(meas_valid), .meas_val(meas_val));

    assign err = CW'(abs_err16(16'(meas_val), 16'(EXPECT)));

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                         tacq_cnt <= '0;
        else if (!pll_on)                   tacq_cnt <= '0;
        else if (tacq_cnt != TW'(T_ACQ))    tacq_cnt <= tacq_cnt + TW'(1);
    end
    assign acq_ready = (tacq_cnt == TW'(T_ACQ));
    assign acq_wr_ok = !auto_bw && pll_on && acq_we && (!acq_wdata || acq_ready);

    plc_hyst_flag #(.CW(CW), .ENTER(TRK_IN), .EXIT(TRK_OUT)) u_acq (
        .clk(ref_clk), .rst_n(rst_n), .clear(!pll_on),
        .load_en(acq_wr_ok), .load_val(acq_wdata),
        .eval(auto_bw && meas_valid), .err(err), .flag(acq));

    plc_hyst_flag #(.CW(CW), .ENTER(LCK_IN), .EXIT(LCK_OUT)) u_lock (
        .clk(ref_clk), .rst_n(rst_n), .clear(!pll_on || !auto_bw),
        .load_en(1'b0), .load_val(1'b0),
        .eval(meas_valid), .err(err), .flag(lock));

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_prev <= 1'b0;
            irq       <= 1'b0;
        end else begin
            lock_prev <= lock;
            if ((lock ^ lock_prev) && auto_bw && irq_en) irq <= 1'b1;
            else if (irq_clr)                            irq <= 1'b0;
        end
    end

    assign vco_safe = lock;

    // Manual mode holds lock low (R7)
    p_manual_no_lock_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !auto_bw |=> !lock);

    // Manual mode never raises the interrupt (R7)
    p_manual_no_irq_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!auto_bw && !irq) |=> !irq);

    // Interrupt only follows a lock change while enabled (R5)
    p_irq_cause_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(lock) != $past(lock_prev)) && $past(irq_en));

    // Early manual write of 1 is refused (R8)
    p_early_acq_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($rose(acq) && !$past(auto_bw)) |-> $past(acq_ready));

    // Disable clears both flags (R9)
    p_off_clears_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pll_on |=> !acq && !lock);

endmodule

// File: tb/pll_lock_ctrl_test.sv
`timescale 1ns/1ps
module pll_lock_ctrl_test;
    logic ref_clk = 1'b0, vco_clk = 1'b0, rst_n = 1'b0;
    logic pll_on = 1'b0, auto_bw = 1'b1, irq_en = 1'b0;
    logic acq_we = 1'b0, acq_wdata = 1'b0, irq_clr = 1'b0;
    logic acq, lock, irq, vco_safe;
    real  vco_half = 0.3125;
    int   checks = 0, failures = 0;
    bit   done = 1'b0;

    pll_lock_ctrl uut (
        .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .pll_on(pll_on),
        .auto_bw(auto_bw), .irq_en(irq_en), .acq_we(acq_we), .acq_wdata(acq_wdata),
        .irq_clr(irq_clr), .acq(acq), .lock(lock), .irq(irq), .vco_safe(vco_safe));

    always #2.5 ref_clk = ~ref_clk;
    initial forever #(vco_half) vco_clk = ~vco_clk;

    // Counts over a 16-cycle window: half period = 40 ns / count
    task automatic set_count(input int c);
        vco_half = 40.0 / c;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 acq", acq, 1'b0);
        chk("R1 lock", lock, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 vco_safe", vco_safe, 1'b0);
    endtask

    task automatic t_auto_hysteresis();
        irq_en = 1'b1;
        set_count(108); pll_on = 1'b1; cyc(90);
        chk("R4 far acq", acq, 1'b0);
        chk("R4 far lock", lock, 1'b0);
        set_count(121); cyc(80);
        chk("R2 no enter at err7", acq, 1'b0);
        chk("R3 no enter at err7", lock, 1'b0);
        set_count(128); cyc(80);
        chk("R2 enter at err0", acq, 1'b1);
        chk("R3 enter at err0", lock, 1'b1);
        chk("R10 safe follows lock", vco_safe, 1'b1);
        chk("R5 irq on rising lock", irq, 1'b1);
        pulse_clr();
        chk("R6 irq cleared", irq, 1'b0);
        set_count(135); cyc(80);
        chk("R2 hold at err7", acq, 1'b1);
        chk("R3 hold at err7", lock, 1'b1);
        chk("R6 irq stays clear", irq, 1'b0);
        set_count(116); cyc(80);
        chk("R3 exit at err12", lock, 1'b0);
        chk("R2 hold at err12", acq, 1'b1);
        chk("R10 safe low", vco_safe, 1'b0);
        chk("R5 irq on falling lock", irq, 1'b1);
        pulse_clr();
        set_count(108); cyc(80);
        chk("R2 exit at err20", acq, 1'b0);
        chk("R6 no new irq", irq, 1'b0);
    endtask

    task automatic t_irq_disabled();
        irq_en = 1'b0;
        set_count(128); cyc(80);
        chk("R3 relock", lock, 1'b1);
        chk("R5 no irq when disabled", irq, 1'b0);
    endtask

    task automatic t_pll_off();
        pll_on = 1'b0; cyc(1);
        chk("R9 acq off", acq, 1'b0);
        chk("R9 lock off", lock, 1'b0);
        cyc(5);
        pll_on = 1'b1; cyc(20);
        chk("R9 no lock before new measurement", lock, 1'b0);
        cyc(70);
        chk("R9 relock after restart", lock, 1'b1);
        pll_on = 1'b0; cyc(3);
    endtask

    task automatic t_manual();
        auto_bw = 1'b0; irq_en = 1'b1; pll_on = 1'b1; cyc(5);
        acq_wdata = 1'b1; acq_we = 1'b1; cyc(1); acq_we = 1'b0;
        chk("R8 early write ignored", acq, 1'b0);
        cyc(70);
        acq_we = 1'b1; cyc(1); acq_we = 1'b0;
        chk("R7 write 1 accepted", acq, 1'b1);
        cyc(60);
        chk("R7 lock held low", lock, 1'b0);
        chk("R7 no irq", irq, 1'b0);
        acq_wdata = 1'b0; acq_we = 1'b1; cyc(1); acq_we = 1'b0;
        chk("R8 write 0 accepted", acq, 1'b0);
    endtask

    task automatic t_auto_to_manual();
        auto_bw = 1'b1; cyc(80);
        chk("R3 locked in auto", lock, 1'b1);
        pulse_clr();
        auto_bw = 1'b0; cyc(1);
        chk("R7 lock drops on manual", lock, 1'b0);
        cyc(10);
        chk("R7 no irq on manual switch", irq, 1'b0);
    endtask

    initial begin
        cyc(3); rst_n = 1'b1; cyc(2);
        t_reset();
        t_auto_hysteresis();
        t_irq_disabled();
        t_pll_off();
        t_manual();
        t_auto_to_manual();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge ref_clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule